// File: doc/BRIEF.md
# Two-Level Aperture Address Translator

This block sits between a requester that issues addresses inside a graphics aperture window and the system memory. An address that lands inside the window is translated to a system physical address by walking a two-level table held in memory. A 4 KiB directory, found through a base register, is indexed by bits 31:22 of the incoming address. The selected directory word points to a 4 KiB page of leaf words. Bits 21:12 pick the leaf word, and the leaf supplies the physical page frame. Because the directory index uses the whole upper address and not an offset from the window start, the window base picks the first directory slot that is used.

A small register file sets the directory base, the window base, the window size and an enable bit, and holds a self-clearing invalidate command. A fully associative cache of eight completed translations is checked before any memory fetch. Only one request is in flight at a time. The memory port reads one 32-bit word per handshake. The response port returns a translated address, a passthrough of the original address, or a fault.

Top module: `aperture_xlate`

## Requirements
- R1: When the enable bit (register 3, bit 0) is 0, or the request address lies outside the window, the response has kind 1 (passthrough), returns the request address unchanged and makes no memory read. The window starts at the window base (register 1), aligned down to the window size.
- R2: The window size is 32 MiB shifted left by the size code. The code sits in bits 2:1 of register 2, which reads back with bit 0 as 0. A write to register 2 changes the code only when bit 0 of the written data is 1. The code is 0 after reset.
- R3: A walk first reads address {dirbase[31:12], addr[31:22], 2'b00}. It then reads address {dir_word[31:12], addr[21:12], 2'b00}. The directory base is register 0, and its low 12 bits read as 0.
- R4: When both words have bit 0 set, the response has kind 0 and address {leaf_word[31:12], addr[11:0]}.
- R5: When the directory word or the leaf word has bit 0 clear, the response has kind 2 and address 0. A faulting page is not cached.
- R6: A request to a 4 KiB page held in the cache makes no memory read and is answered in the cycle after it is accepted.
- R7: The cache holds 8 translations and replaces them in round-robin order. After 8 newer pages have been filled, the oldest page needs a new walk.
- R8: Writing data with bit 0 set to register 4 starts a flush of the cache. Register 4 reads 1 for exactly 8 cycles after the write and then reads 0. No request is accepted during those cycles. After the flush, every page needs a new walk.
- R9: Writing 0 to the enable bit empties the cache at once, so a page that was cached needs a new walk after the bit is set again.
- R10: req_ready is low from the acceptance of a request until its response has been taken. The response address and kind stay stable while rsp_ready is low.
- R11: When the directory base is 0, an in-window request that misses the cache gets kind 2 with no memory read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 directory base, 1 window base, 2 size control, 3 enable, 4 invalidate |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | 32 | Bus address to translate |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_addr | output | 32 | Result address |
| rsp_kind | output | 2 | 0 translated, 1 passthrough, 2 fault |
| mem_req | output | 1 | Memory word read request, held until acknowledged |
| mem_addr | output | 32 | Byte address of the word to read |
| mem_ack | input | 1 | Read data valid, completes the read |
| mem_rdata | input | 32 | Read data |

## Verification
A wrong cache tag, a stale valid bit or a bad replacement pointer shows up on the first repeat request to an affected page. It appears either as a result from the cache where a walk was due, or as a walk where the cache should have answered. The bench tells these apart by counting memory reads per request and by measuring how long each answer takes. A wrong slice in either fetch address appears on mem_addr in the same walk. Because the bench's memory image returns different data for neighbouring slots, the same error also changes rsp_addr in the response that follows. Flush and enable faults are caught by the register 4 busy-cycle count and by the next request to a page that was cached before.

// File: rtl/aperture_xlate.sv
module aperture_xlate #(
  parameter int AW      = 32,
  parameter int SLOTS   = 8,
  parameter int PG      = 12,
  parameter int DSH     = 22,
  parameter int BASE_SH = 25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_sel,
  input  logic [AW-1:0] reg_wdata,
  output logic [AW-1:0] reg_rdata,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [AW-1:0] rsp_addr,
  output logic [1:0]    rsp_kind,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [AW-1:0] mem_rdata
);
  localparam int IW  = $clog2(SLOTS);
  localparam int FW  = AW - PG;
  localparam logic [1:0] K_OK = 2'd0, K_PASS = 2'd1, K_FAULT = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_DIR, S_LEAF, S_RSP} st_t;
  st_t st;

  logic [AW-1:0] dir_base, ap_base, cur_addr;
  logic [FW-1:0] dir_pfn;
  logic [1:0]    sz_code;
  logic          xl_en, flush_busy, stale;
  logic [IW-1:0] flush_idx, rr_ptr;
  logic [1:0]    kind_q;
  logic [AW-1:0] addr_q;

  logic [SLOTS-1:0] c_vld;
  logic [FW-1:0]    c_tag [SLOTS];
  logic [FW-1:0]    c_pfn [SLOTS];
  logic [SLOTS-1:0] hit_vec;
  logic [FW-1:0]    hit_pfn;
  logic             hit;

  logic unused_bits;
  assign unused_bits = ^mem_rdata[PG-1:1];

  logic flush_go, en_clear, accept, in_win, fill_en;
  logic [AW-1:0] win_span, win_mask;

  assign flush_go = reg_we && reg_sel == 3'd4 && reg_wdata[0];
  assign en_clear = reg_we && reg_sel == 3'd3 && !reg_wdata[0];
  assign req_ready = (st == S_IDLE) && !flush_busy;
  assign accept    = req_valid && req_ready;

  assign win_span = {{(AW-1){1'b0}}, 1'b1} << (BASE_SH + int'(sz_code));
  assign win_mask = ~(win_span - 1'b1);
  assign in_win   = (req_addr & win_mask) == (ap_base & win_mask);

  for (genvar i = 0; i < SLOTS; i++) begin : g_cmp
    assign hit_vec[i] = c_vld[i] && (c_tag[i] == req_addr[AW-1:PG]);
  end

  always_comb begin
    hit_pfn = '0;
    for (int i = 0; i < SLOTS; i++)
      if (hit_vec[i]) hit_pfn = hit_pfn | c_pfn[i];
  end
  assign hit = |hit_vec;

  assign mem_req  = (st == S_DIR) || (st == S_LEAF);
  assign mem_addr = (st == S_DIR) ? {dir_base[AW-1:PG], cur_addr[AW-1:DSH], 2'b00}
                                  : {dir_pfn, cur_addr[DSH-1:PG], 2'b00};

  assign fill_en = (st == S_LEAF) && mem_ack && mem_rdata[0] && !stale &&
                   !flush_busy && !flush_go && !en_clear && xl_en;

  assign rsp_valid = (st == S_RSP);
  assign rsp_addr  = addr_q;
  assign rsp_kind  = kind_q;

  always_comb begin
    case (reg_sel)
      3'd0:    reg_rdata = dir_base;
      3'd1:    reg_rdata = ap_base;
      3'd2:    reg_rdata = {{(AW-3){1'b0}}, sz_code, 1'b0};
      3'd3:    reg_rdata = {{(AW-1){1'b0}}, xl_en};
      3'd4:    reg_rdata = {{(AW-1){1'b0}}, flush_busy};
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_base   <= '0;
      ap_base    <= '0;
      sz_code    <= '0;
      xl_en      <= 1'b0;
      flush_busy <= 1'b0;
      flush_idx  <= '0;
    end else begin
      if (reg_we) begin
        case (reg_sel)
          3'd0: dir_base <= {reg_wdata[AW-1:PG], {PG{1'b0}}};
          3'd1: ap_base  <= reg_wdata;
          3'd2: if (reg_wdata[0]) sz_code <= reg_wdata[2:1];
          3'd3: xl_en    <= reg_wdata[0];
          default: ;
        endcase
      end
      if (flush_go) begin
        flush_busy <= 1'b1;
        flush_idx  <= '0;
      end else if (flush_busy) begin
        flush_idx <= flush_idx + 1'b1;
        if (flush_idx == IW'(SLOTS-1)) flush_busy <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cur_addr <= '0;
      dir_pfn  <= '0;
      addr_q   <= '0;
      kind_q   <= K_OK;
      stale    <= 1'b0;
    end else begin
      if ((flush_go || en_clear) && st != S_IDLE) stale <= 1'b1;
      case (st)
        S_IDLE: if (accept) begin
          cur_addr <= req_addr;
          stale    <= 1'b0;
          if (!xl_en || !in_win) begin
            addr_q <= req_addr;
            kind_q <= K_PASS;
            st     <= S_RSP;
          end else if (hit) begin
            addr_q <= {hit_pfn, req_addr[PG-1:0]};
            kind_q <= K_OK;
            st     <= S_RSP;
          end else if (dir_base == '0) begin
            addr_q <= '0;
            kind_q <= K_FAULT;
            st     <= S_RSP;
          end else begin
            st <= S_DIR;
          end
        end
        S_DIR: if (mem_ack) begin
          if (!mem_rdata[0]) begin
            addr_q <= '0;
            kind_q <= K_FAULT;
            st     <= S_RSP;
          end else begin
            dir_pfn <= mem_rdata[AW-1:PG];
            st      <= S_LEAF;
          end
        end
        S_LEAF: if (mem_ack) begin
          if (!mem_rdata[0]) begin
            addr_q <= '0;
            kind_q <= K_FAULT;
          end else begin
            addr_q <= {mem_rdata[AW-1:PG], cur_addr[PG-1:0]};
            kind_q <= K_OK;
          end
          st <= S_RSP;
        end
        S_RSP: if (rsp_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_vld  <= '0;
      rr_ptr <= '0;
    end else if (en_clear) begin
      c_vld <= '0;
    end else if (flush_busy) begin
      c_vld[flush_idx] <= 1'b0;
    end else if (fill_en) begin
      c_vld[rr_ptr] <= 1'b1;
      rr_ptr        <= rr_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      c_tag[rr_ptr] <= cur_addr[AW-1:PG];
      c_pfn[rr_ptr] <= mem_rdata[AW-1:PG];
    end
  end

  assert_single_walk_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready);

  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr) && $stable(rsp_kind)));

  assert_fault_noaddr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_kind == K_FAULT) |-> (rsp_addr == '0));

  assert_mem_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  assert_flush_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flush_busy) |-> (c_vld == '0));
endmodule

// File: tb/tb_aperture_xlate.sv
module tb_aperture_xlate;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_LAT = 2;

  logic clk = 0, rst_n = 0;
  logic reg_we = 0;
  logic [2:0] reg_sel = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic req_valid = 0, req_ready;
  logic [31:0] req_addr = 0;
  logic rsp_valid, rsp_ready = 0;
  logic [31:0] rsp_addr;
  logic [1:0] rsp_kind;
  logic mem_req, mem_ack = 0;
  logic [31:0] mem_addr, mem_rdata = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  aperture_xlate dut (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_addr(rsp_addr), .rsp_kind(rsp_kind),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata));

  logic [31:0] mem_img [logic [31:0]];
  logic [31:0] rd_log [16];
  int rd_n = 0, lat_cnt = 0;
  int errs = 0, checks = 0;
  bit ready_leak, hold_bad;

  always @(posedge clk) begin
    if (mem_ack) mem_ack <= 1'b0;
    else if (mem_req) begin
      if (lat_cnt == MEM_LAT - 1) begin
        lat_cnt <= 0;
        mem_ack <= 1'b1;
        mem_rdata <= mem_img.exists(mem_addr) ? mem_img[mem_addr] : 32'h0;
        rd_log[rd_n % 16] <= mem_addr;
        rd_n <= rd_n + 1;
      end else lat_cnt <= lat_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_sel = s; reg_wdata = d;
    @(posedge clk); @(negedge clk); reg_we = 0;
  endtask

  task automatic rd_reg(input logic [2:0] s, output logic [31:0] v);
    reg_sel = s; #1; v = reg_rdata;
  endtask

  task automatic do_req(input logic [31:0] a, input int hold, output logic [1:0] k,
                        output logic [31:0] pa, output int lat, output int nrd);
    int r0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    r0 = rd_n; req_valid = 1; req_addr = a; rsp_ready = 0;
    @(posedge clk); @(negedge clk); req_valid = 0; lat = 1;
    while (!rsp_valid && lat < 100) begin
      if (req_ready) ready_leak = 1;
      @(negedge clk); lat++;
    end
    if (req_ready) ready_leak = 1;
    k = rsp_kind; pa = rsp_addr;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      if (!rsp_valid || rsp_addr != pa || rsp_kind != k || req_ready) hold_bad = 1;
    end
    rsp_ready = 1; @(posedge clk); @(negedge clk); rsp_ready = 0;
    nrd = rd_n - r0;
  endtask

  task automatic expect_xl(input logic [31:0] a, input logic [1:0] ek, input logic [31:0] ea,
                           input int ereads, input string tag);
    logic [1:0] k; logic [31:0] pa; int lat, nrd;
    do_req(a, 0, k, pa, lat, nrd);
    chk(k == ek, {tag, " kind"}, 32'(k), 32'(ek));
    chk(pa == ea, {tag, " addr"}, pa, ea);
    chk(nrd == ereads, {tag, " reads"}, nrd, ereads);
  endtask

  task automatic flush_wait();
    logic [31:0] v;
    wr_reg(3'd4, 32'h1);
    rd_reg(3'd4, v);
    while (v != 0) begin @(negedge clk); rd_reg(3'd4, v); end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    @(negedge clk);
    chk(req_ready == 1 && rsp_valid == 0 && mem_req == 0, "reset R10 handshake idle",
        {29'b0, req_ready, rsp_valid, mem_req}, 32'h4);
    for (int s = 0; s < 5; s++) begin
      rd_reg(3'(s), v);
      chk(v == 0, $sformatf("reset R2 register %0d", s), v, 0);
    end
  endtask

  task automatic t_setup();
    mem_img[32'h0010_0400] = 32'h0020_0001;
    mem_img[32'h0010_0404] = 32'h0020_1001;
    for (int p = 0; p < 16; p++)
      mem_img[32'h0020_0000 + 32'(p*4)] = (p == 5) ? 32'h0 : (32'h8000_0000 + 32'(p << 12)) | 32'h1;
    mem_img[32'h0020_1000] = 32'h9000_0001;
    wr_reg(3'd0, 32'h0010_0ABC);
    wr_reg(3'd1, 32'h4000_0000);
    wr_reg(3'd2, 32'h1);
    wr_reg(3'd3, 32'h1);
  endtask

  task automatic t_size();
    logic [31:0] v;
    rd_reg(3'd0, v);
    chk(v == 32'h0010_0000, "R3 directory base low bits", v, 32'h0010_0000);
    wr_reg(3'd2, 32'h6);
    rd_reg(3'd2, v);
    chk(v == 0, "R2 size ignored without bit 0", v, 0);
    expect_xl(32'h4300_0000, 2'd1, 32'h4300_0000, 0, "R2 outside 32MiB window");
    wr_reg(3'd2, 32'h3);
    rd_reg(3'd2, v);
    chk(v == 32'h2, "R2 size code 1 readback", v, 32'h2);
    expect_xl(32'h4300_0000, 2'd2, 32'h0, 1, "R2 inside 64MiB window");
    expect_xl(32'h4400_0000, 2'd1, 32'h4400_0000, 0, "R2 above 64MiB window");
  endtask

  task automatic t_pass();
    expect_xl(32'h1234_5678, 2'd1, 32'h1234_5678, 0, "R1 outside window");
  endtask

  task automatic t_walk();
    int r0;
    r0 = rd_n;
    expect_xl(32'h4000_3ABC, 2'd0, 32'h8000_3ABC, 2, "R4 translate");
    chk(rd_log[r0 % 16] == 32'h0010_0400, "R3 directory fetch", rd_log[r0 % 16], 32'h0010_0400);
    chk(rd_log[(r0+1) % 16] == 32'h0020_000C, "R3 leaf fetch", rd_log[(r0+1) % 16], 32'h0020_000C);
    r0 = rd_n;
    expect_xl(32'h4040_0123, 2'd0, 32'h9000_0123, 2, "R4 second directory slot");
    chk(rd_log[r0 % 16] == 32'h0010_0404, "R3 directory slot 257", rd_log[r0 % 16], 32'h0010_0404);
    chk(rd_log[(r0+1) % 16] == 32'h0020_1000, "R3 leaf page 2", rd_log[(r0+1) % 16], 32'h0020_1000);
  endtask

  task automatic t_hit();
    logic [1:0] k; logic [31:0] pa; int lat, nrd;
    do_req(32'h4000_3FF0, 0, k, pa, lat, nrd);
    chk(pa == 32'h8000_3FF0 && k == 0, "R6 hit result", pa, 32'h8000_3FF0);
    chk(nrd == 0, "R6 hit no read", nrd, 0);
    chk(lat == 1, "R6 hit latency", lat, 1);
  endtask

  task automatic t_fault();
    expect_xl(32'h4000_5000, 2'd2, 32'h0, 2, "R5 leaf invalid");
    expect_xl(32'h4000_5010, 2'd2, 32'h0, 2, "R5 fault not cached");
    expect_xl(32'h4080_0000, 2'd2, 32'h0, 1, "R5 directory invalid");
  endtask

  task automatic t_rr();
    int pg [8] = '{0, 1, 2, 3, 4, 6, 7, 8};
    flush_wait();
    foreach (pg[i])
      expect_xl(32'h4000_0000 + 32'(pg[i] << 12), 2'd0, 32'h8000_0000 + 32'(pg[i] << 12), 2, "R7 fill");
    expect_xl(32'h4000_0004, 2'd0, 32'h8000_0004, 0, "R7 oldest still held");
    expect_xl(32'h4000_9000, 2'd0, 32'h8000_9000, 2, "R7 ninth fill");
    expect_xl(32'h4000_0008, 2'd0, 32'h8000_0008, 2, "R7 oldest replaced");
    expect_xl(32'h4000_2000, 2'd0, 32'h8000_2000, 0, "R7 third page kept");
  endtask

  task automatic t_enable();
    expect_xl(32'h4000_3000, 2'd0, 32'h8000_3000, 0, "R9 cached before disable");
    wr_reg(3'd3, 32'h0);
    expect_xl(32'h4000_3000, 2'd1, 32'h4000_3000, 0, "R1 disabled passthrough");
    wr_reg(3'd3, 32'h1);
    expect_xl(32'h4000_3000, 2'd0, 32'h8000_3000, 2, "R9 cache emptied by disable");
  endtask

  task automatic t_flush();
    logic [31:0] v; int n = 0; bit rdy_seen = 0;
    wr_reg(3'd4, 32'h1);
    rd_reg(3'd4, v);
    while (v != 0 && n < 50) begin
      if (req_ready) rdy_seen = 1;
      n++; @(negedge clk); rd_reg(3'd4, v);
    end
    chk(n == 8, "R8 busy cycles", n, 8);
    chk(!rdy_seen, "R8 no accept while busy", 32'(rdy_seen), 0);
    expect_xl(32'h4000_3000, 2'd0, 32'h8000_3000, 2, "R8 walk after flush");
  endtask

  task automatic t_hold();
    logic [1:0] k; logic [31:0] pa; int lat, nrd;
    ready_leak = 0; hold_bad = 0;
    do_req(32'h4000_B044, 3, k, pa, lat, nrd);
    chk(pa == 32'h8000_B044, "R10 held response value", pa, 32'h8000_B044);
    chk(!hold_bad, "R10 response stable while stalled", 32'(hold_bad), 0);
    chk(!ready_leak, "R10 ready low during walk", 32'(ready_leak), 0);
  endtask

  task automatic t_detach();
    wr_reg(3'd0, 32'h0);
    expect_xl(32'h4000_A000, 2'd2, 32'h0, 0, "R11 detached tables");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    t_reset();
    t_setup();
    t_size();
    t_pass();
    t_walk();
    t_hit();
    t_fault();
    t_rr();
    t_enable();
    t_flush();
    t_hold();
    t_detach();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule